// File: doc/BRIEF.md
# SPI Serial Memory Read Slave

This block is the read path of a byte-addressed serial memory behind an SPI slave port in mode 0. The block uses the serial clock directly as its clock. While chip select is low it samples an 8-bit instruction and then a 16-bit address on the data input, most significant bit first, one bit per rising edge. If the instruction is a read and no write cycle is busy, it streams bytes from an internal array on the data output. Output bits change on falling edges, and the address advances after every byte, so one command can read the whole array.

The array holds `2**ADDR_W` bytes. Address bits above `ADDR_W-1` are ignored: `ADDR_W = 14` gives a 128 Kbit part and `ADDR_W = 15` gives a 256 Kbit part. A preload port writes the array for test. Raising chip select ends a transaction at any bit and puts the output in its high-impedance state. That state appears as `misoOe` low, and a pad cell outside the block builds the tri-state driver from the pair.

Top module: `spiMemRead`

## Requirements
- R1: While `csN` is high, `misoOe` is 0. Each fall of `csN` starts a new instruction, whatever the previous transaction did.
- R2: The first 8 rising edges of `sclk` after `csN` falls sample the instruction and the next 16 sample the address, MSB first. `misoOe` stays 0 for all of these 24 bits.
- R3: For instruction 8'h03 with `writeBusy` low, the falling edge after the 24th rising edge drives bit 7 of the byte at the given address on `misoData`, with `misoOe` at 1. Each later falling edge drives the next lower bit. Any start address is allowed.
- R4: While `csN` stays low, the byte at the next address follows bit 0 on the very next falling edge, with no gap.
- R5: After address `2**ADDR_W-1`, the read continues at address 0.
- R6: Address bits 15 down to `ADDR_W` have no effect on which byte is read.
- R7: A rise of `csN` at any bit position, including mid-address or mid-byte, drops `misoOe` at once. The next transaction behaves normally.
- R8: If `writeBusy` is high at the rising edge that samples the 8th instruction bit, the read is refused and `misoOe` stays 0 until `csN` rises.
- R9: Any instruction other than 8'h03 keeps `misoOe` at 0 until `csN` rises.
- R10: When `loadEn` is high, a rising edge of `sclk` writes `loadData` into the array at `loadAddr`. Later reads return that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock, mode 0 |
| csN | input | 1 | Chip select, active low; high also clears the block |
| mosi | input | 1 | Serial data in, sampled on rising edge |
| writeBusy | input | 1 | High while a write cycle is in progress |
| loadEn | input | 1 | Preload write enable |
| loadAddr | input | ADDR_W | Preload byte address |
| loadData | input | 8 | Preload byte value |
| misoData | output | 1 | Serial data out, changes on falling edge |
| misoOe | output | 1 | Output enable for misoData; 0 means high impedance |

## Verification
The first data bit is due on the falling edge right after the 24th rising edge. Every later bit, including the MSB of each following byte, is due one falling edge after the previous bit. A monitor therefore samples `misoData` 1 ns after each falling edge and packs eight bits into a byte before it compares. The driver pushes the expected bytes for each read into a queue, and the queue must be empty shortly after chip select rises. Refused and ignored commands, and every command and address bit, are checked by sampling `misoOe` at the same point after each falling edge. After an abort, `misoOe` is sampled 1 ns after the rise of `csN`.

// File: rtl/spiMemReadPkg.sv
package spiMemReadPkg;
  localparam int CMD_BITS = 8;
  localparam int ADDR_BITS = 16;
  localparam logic [CMD_BITS-1:0] OP_READ = 8'h03;

  typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DATA, PH_IGNORE} phase_t;

  typedef struct packed {
    logic       addrShift;
    logic       addrLoad;
    logic       advance;
    logic       drive;
    logic [2:0] bitSel;
  } ctlStrobe_t;
endpackage

// File: rtl/spiMemReadCtrl.sv
module spiMemReadCtrl
  import spiMemReadPkg::*;
(
  input  logic       sclk,
  input  logic       csN,
  input  logic       mosi,
  input  logic       writeBusy,
  output ctlStrobe_t strobe
);
  localparam int CNT_W = $clog2(ADDR_BITS);
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BITS - 1);

  phase_t phase;
  logic [CNT_W-1:0] bitCnt;
  logic [CMD_BITS-2:0] opShift;
  logic [2:0] dataBit;
  logic [CMD_BITS-1:0] opNext;

  assign opNext = {opShift, mosi};

  always_ff @(posedge sclk or posedge csN) begin
    if (csN) begin
      phase   <= PH_CMD;
      bitCnt  <= '0;
      opShift <= '0;
      dataBit <= '0;
    end else begin
      case (phase)
        PH_CMD: begin
          opShift <= opNext[CMD_BITS-2:0];
          if (bitCnt == CMD_LAST) begin
            bitCnt <= '0;
            phase  <= (opNext == OP_READ && !writeBusy) ? PH_ADDR : PH_IGNORE;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        PH_ADDR: begin
          if (bitCnt == ADDR_LAST) begin
            bitCnt  <= '0;
            dataBit <= '0;
            phase   <= PH_DATA;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        PH_DATA: dataBit <= dataBit + 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.addrShift = (phase == PH_ADDR);
    strobe.addrLoad  = (phase == PH_ADDR) && (bitCnt == ADDR_LAST);
    strobe.advance   = (phase == PH_DATA) && (dataBit == 3'd7);
    strobe.drive     = (phase == PH_DATA);
    strobe.bitSel    = dataBit;
  end

  // R2: the instruction phase lasts exactly CMD_BITS rising edges
  p_cmd_len_r2: assert property (@(posedge sclk) disable iff (csN)
    (phase == PH_CMD && bitCnt != CMD_LAST) |=> (phase == PH_CMD));

  // R8: a busy write cycle at the last instruction bit refuses the read
  p_busy_refuse_r8: assert property (@(posedge sclk) disable iff (csN)
    (phase == PH_CMD && bitCnt == CMD_LAST && writeBusy) |=> (phase == PH_IGNORE));

  // R9: a refused or unknown command stays inert until chip select rises
  p_ignore_hold_r9: assert property (@(posedge sclk) disable iff (csN)
    (phase == PH_IGNORE) |=> (phase == PH_IGNORE));
endmodule

// File: rtl/spiMemReadData.sv
module spiMemReadData
  import spiMemReadPkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              sclk,
  input  logic              csN,
  input  logic              mosi,
  input  ctlStrobe_t        strobe,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [7:0]        loadData,
  output logic              misoData,
  output logic              misoOe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

  logic [7:0] memArray [DEPTH];
  logic [ADDR_W-2:0] addrShift;
  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] fullAddr;
  logic [7:0] curByte;

  // only the low ADDR_W bits are kept; upper address bits fall off the shifter
  assign fullAddr = {addrShift, mosi};
  assign curByte  = memArray[addrReg];

  always_ff @(posedge sclk) begin
    if (loadEn) memArray[loadAddr] <= loadData;
  end

  always_ff @(posedge sclk or posedge csN) begin
    if (csN) begin
      addrShift <= '0;
      addrReg   <= '0;
    end else begin
      if (strobe.addrShift) addrShift <= fullAddr[ADDR_W-2:0];
      if (strobe.addrLoad) addrReg <= fullAddr;
      else if (strobe.advance) addrReg <= addrReg + 1'b1;
    end
  end

  always_ff @(negedge sclk or posedge csN) begin
    if (csN) begin
      misoOe   <= 1'b0;
      misoData <= 1'b0;
    end else begin
      misoOe   <= strobe.drive;
      misoData <= strobe.drive ? curByte[3'd7 - strobe.bitSel] : 1'b0;
    end
  end

  // R2: output stays off while the address is being shifted in
  p_hiz_addr_r2: assert property (@(posedge sclk) disable iff (csN)
    strobe.addrShift |-> !misoOe);

  // R4: each completed byte moves the read address on by one
  p_addr_step_r4: assert property (@(posedge sclk) disable iff (csN)
    (strobe.advance && addrReg != TOP_ADDR) |=> (addrReg == $past(addrReg) + 1'b1));

  // R5: the read address rolls from the top location to zero
  p_addr_wrap_r5: assert property (@(posedge sclk) disable iff (csN)
    (strobe.advance && addrReg == TOP_ADDR) |=> (addrReg == '0));
endmodule

// File: rtl/spiMemRead.sv
module spiMemRead
  import spiMemReadPkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              sclk,
  input  logic              csN,
  input  logic              mosi,
  input  logic              writeBusy,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [7:0]        loadData,
  output logic              misoData,
  output logic              misoOe
);
  ctlStrobe_t strobe;

  spiMemReadCtrl ctrl_i (
    .sclk      (sclk),
    .csN       (csN),
    .mosi      (mosi),
    .writeBusy (writeBusy),
    .strobe    (strobe)
  );

  spiMemReadData #(.ADDR_W(ADDR_W)) data_i (
    .sclk     (sclk),
    .csN      (csN),
    .mosi     (mosi),
    .strobe   (strobe),
    .loadEn   (loadEn),
    .loadAddr (loadAddr),
    .loadData (loadData),
    .misoData (misoData),
    .misoOe   (misoOe)
  );
endmodule

// File: tb/spiMemRead_tb_top.sv
`timescale 1ns/1ps
module spiMemRead_tb_top;
  localparam int ADDR_W = 10;
  localparam int DEPTH = 1 << ADDR_W;

  logic sclk = 1'b0;
  logic csN = 1'b1;
  logic mosi = 1'b0;
  logic writeBusy = 1'b0;
  logic loadEn = 1'b0;
  logic [ADDR_W-1:0] loadAddr = '0;
  logic [7:0] loadData = '0;
  logic misoData;
  logic misoOe;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  logic [7:0] model [DEPTH];
  logic [7:0] expV [$];
  string expT [$];

  spiMemRead #(.ADDR_W(ADDR_W)) dut_i (
    .sclk(sclk), .csN(csN), .mosi(mosi), .writeBusy(writeBusy),
    .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData),
    .misoData(misoData), .misoOe(misoOe)
  );

  always #2 sclk = ~sclk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pack output bits into bytes and compare against the queue
  initial begin
    logic [7:0] acc;
    int nBit;
    nBit = 0;
    acc = '0;
    forever begin
      @(negedge sclk);
      #1;
      if (csN) begin
        nBit = 0;
      end else if (misoOe) begin
        acc = {acc[6:0], misoData};
        nBit++;
        if (nBit == 8) begin
          nBit = 0;
          if (expV.size() == 0) begin
            check(0, "R4 unexpected byte", acc, 0);
          end else begin
            logic [7:0] e;
            string t;
            e = expV.pop_front();
            t = expT.pop_front();
            check(acc == e, t, acc, e);
          end
        end
      end
    end
  end

  // drive the top nb bits of a 24-bit command word, one per falling edge
  task automatic sendBits(input logic [23:0] v, input int nb, inout int hzBad);
    for (int i = 23; i > 23 - nb; i--) begin
      mosi <= v[i];
      #1;
      if (misoOe) hzBad++;
      @(negedge sclk);
    end
  endtask

  task automatic loadByte(input int a, input logic [7:0] d);
    @(negedge sclk);
    loadEn <= 1'b1;
    loadAddr <= ADDR_W'(a);
    loadData <= d;
    model[a] = d;
    @(negedge sclk);
    loadEn <= 1'b0;
  endtask

  task automatic doRead(input logic [15:0] a, input int nBytes, input int extraBits, input string tag);
    int eff;
    int hzBad;
    hzBad = 0;
    eff = int'(a[ADDR_W-1:0]);
    for (int k = 0; k < nBytes; k++) begin
      expV.push_back(model[(eff + k) % DEPTH]);
      expT.push_back(tag);
    end
    @(negedge sclk);
    csN <= 1'b0;
    sendBits({8'h03, a}, 24, hzBad);
    repeat (nBytes * 8 + extraBits) @(negedge sclk);
    csN <= 1'b1;
    #1;
    check(!misoOe, "R7 output off right after csN rise", misoOe, 0);
    check(hzBad == 0, "R2 output off during command and address", hzBad, 0);
    repeat (2) @(negedge sclk);
    check(expV.size() == 0, {tag, " all bytes delivered"}, expV.size(), 0);
    expV.delete();
    expT.delete();
  endtask

  task automatic refusedCmd(input logic [7:0] op, input logic busy, input string tag);
    int bad;
    bad = 0;
    @(negedge sclk);
    writeBusy <= busy;
    csN <= 1'b0;
    sendBits({op, 16'h0010}, 24, bad);
    for (int i = 0; i < 16; i++) begin
      #1;
      if (misoOe) bad++;
      @(negedge sclk);
    end
    csN <= 1'b1;
    writeBusy <= 1'b0;
    check(bad == 0, tag, bad, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int hz;
    #1;
    check(!misoOe, "R1 output off while csN high at start", misoOe, 0);

    // R10: preload the whole array with a computed pattern
    for (int i = 0; i < DEPTH; i++) loadByte(i, 8'((i * 7) + ((i >> 3) * 13) + 1));
    #1;
    check(!misoOe, "R1 output off while idle", misoOe, 0);

    doRead(16'h0005, 3, 0, "R3 R4 read from 0x005");
    doRead(16'h0002, 1, 0, "R3 single byte");
    doRead(16'h03FE, 4, 0, "R5 wrap past top address");
    doRead(16'hFC17, 2, 0, "R6 upper address bits ignored");
    doRead(16'h0100, 1, 3, "R7 abort mid-byte");
    doRead(16'h0200, 2, 0, "R7 read after mid-byte abort");

    // R7: abort inside the address phase, then a clean read
    hz = 0;
    @(negedge sclk);
    csN <= 1'b0;
    sendBits({8'h03, 16'h0333}, 12, hz);
    csN <= 1'b1;
    #1;
    check(!misoOe && hz == 0, "R7 abort mid-address", misoOe, 0);
    doRead(16'h0041, 2, 0, "R7 read after address abort");

    refusedCmd(8'h03, 1'b1, "R8 busy refuses read");
    doRead(16'h0010, 1, 0, "R8 read accepted once not busy");
    refusedCmd(8'h0B, 1'b0, "R9 unknown opcode 0x0B ignored");
    refusedCmd(8'h83, 1'b0, "R9 unknown opcode 0x83 ignored");

    loadByte(16'h055, 8'hA5);
    doRead(16'h0055, 1, 0, "R10 preloaded value read back");

    #1;
    check(!misoOe, "R1 output off at end", misoOe, 0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule